// File: doc/BRIEF.md
# Short Float Pack/Unpack Converter

This block converts between 32-bit IEEE single-precision words and a compact 16-bit floating-point storage code. A typical use is a filter delay line held in half the memory: samples are packed on the way in and unpacked on the way out. The 16-bit code has a sign bit in bit 15, an unsigned 4-bit exponent in bits 14:11 and an 11-bit fraction in bits 10:0. A non-zero exponent field `e` encodes `(1 + f/2048) * 2^(e - 7)`, so the field equals the IEEE biased exponent minus 120. A zero exponent field encodes the gradual-underflow value `f * 2^-17`. The normal range therefore covers IEEE biased exponents 121 to 135, and the denormal range reaches down to 2^-17 (biased exponent 110).

Packing rounds to nearest, with ties to even. It saturates values that are too large and flushes values that are too small. Unpacking is exact: every 16-bit code maps to exactly one 32-bit float, and denormal codes are renormalised. One mode bit chooses the direction for each transfer. The two-stage pipeline accepts a new word every cycle and returns each result two clocks later.

Top module: `sfp_convert`

## Requirements
- R1: A result appears with `valid_out` high exactly two rising clock edges after the edge that samples `valid_in` high, and `valid_out` is low otherwise. Back-to-back inputs give back-to-back results, and `mode_in` may change on every transfer.
- R2: While `rst_n` is low, `valid_out` and `data_out` are 0, and `valid_in` has no effect.
- R3: With `mode_in` = 0 (pack) and an input biased exponent E from 121 to 135, the result in `data_out[15:0]` is {sign, E-120 in bits 14:11, the top 11 fraction bits in bits 10:0}. Bits 31:16 of `data_out` are 0 for every pack.
- R4: Pack rounds the dropped fraction bits to nearest, ties to even. A round-up out of the fraction field carries into the exponent field.
- R5: Pack of an input with E above 135 (infinity and NaN included), or of an input that rounds past the largest code, gives the input sign with magnitude bits 14:0 all ones.
- R6: Pack of an input with E at most 120 yields a denormal code. The 24-bit significant (hidden 1 included) is shifted right by 133-E and rounded to nearest even. A round-up to 2048 becomes exponent field 1 with fraction 0.
- R7: Pack of a value at or below half of 2^-17 (ties go to even), of zero, or of an IEEE denormal gives a signed zero code (bits 14:0 zero).
- R8: With `mode_in` = 1 (unpack), only `data_in[15:0]` is used. A code with a non-zero exponent field e gives biased exponent e+120, fraction f followed by 12 zeros, and the same sign.
- R9: Unpack of a code with exponent field 0 and fraction f not 0 gives the exact value f*2^-17 as a normalised float, with biased exponent 120 minus the leading-zero count of the 11-bit f.
- R10: Unpack of a code with bits 14:0 zero gives a signed zero.
- R11: Packing the unpacked form of any of the 65,536 codes returns the same code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Input word is present this cycle |
| mode_in | input | 1 | 0 = pack float to short code, 1 = unpack short code to float |
| data_in | input | 32 | IEEE single word (pack) or short code in bits 15:0 (unpack) |
| valid_out | output | 1 | Result is present this cycle |
| data_out | output | 32 | Short code in bits 15:0 with zero above (pack) or IEEE single word (unpack) |

## Verification
The assertions rely on `mode_in` and `data_in` holding known values on every edge where `valid_in` is high. They look two cycles back only after two clean edges following reset, so they never depend on values sampled during reset. The bench drives every input from a known value at the falling edge, including in idle cycles, and holds `rst_n` low from time zero. Each assertion observes only one direction and one operand class, so a check such as the saturation property can never be triggered by an unpack transfer.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
   localparam int unsigned WORD_W  = 32;
   localparam int unsigned WEXP_W  = 8;
   localparam int unsigned WFRAC_W = 23;

   typedef enum logic {
      DIR_PACK   = 1'b0,
      DIR_UNPACK = 1'b1
   } dir_e;

   typedef struct packed {
      logic                sign;
      logic [WEXP_W-1:0]   exp;
      logic [WFRAC_W-1:0]  frac;
   } word_fp_t;
endpackage

// File: rtl/sfp_lzc.sv
module sfp_lzc #(
   parameter int unsigned W = 11
) (
   input  logic [W-1:0]            vec,
   output logic [$clog2(W+1)-1:0]  count
);
   localparam int unsigned CW = $clog2(W + 1);

   if (W < 1) begin : g_bad_width
      $error("sfp_lzc: W must be at least 1");
   end

   // highest set bit wins because the scan runs upward
   always_comb begin
      count = CW'(W);
      for (int i = 0; i < int'(W); i++) begin
         if (vec[i]) count = CW'(int'(W) - 1 - i);
      end
   end
endmodule

// File: rtl/sfp_pack.sv
module sfp_pack
   import sfp_pkg::*;
#(
   parameter int unsigned EXP_W      = 4,
   parameter int unsigned FRAC_W     = 11,
   parameter int unsigned EXP_OFFSET = 120
) (
   input  word_fp_t                   src,
   output logic [EXP_W+FRAC_W:0]      code
);
   localparam int unsigned MAG_W      = EXP_W + FRAC_W;
   localparam int unsigned TOP_BIASED = EXP_OFFSET + (2**EXP_W) - 1;
   localparam int unsigned DROP_W     = WFRAC_W - FRAC_W;
   localparam int unsigned DEN_BASE   = EXP_OFFSET + WFRAC_W + 1 - FRAC_W;
   localparam int unsigned EXT_W      = 2 * (WFRAC_W + 1);
   localparam int unsigned SH_MAX     = EXT_W - 1;

   logic [WFRAC_W:0]   mant;
   logic [EXP_W-1:0]   exp_n;
   logic [FRAC_W-1:0]  keep_n, keep_d;
   logic               guard_n, sticky_n, guard_d, sticky_d;
   logic [8:0]         den_sh;
   logic [5:0]         sh_c;
   logic [EXT_W-1:0]   ext;
   logic               is_sat, is_norm, guard, sticky, rnd;
   logic [MAG_W-1:0]   base, mag;
   logic [MAG_W:0]     sum;

   // normal path: direct field extraction
   always_comb begin
      mant     = {1'b1, src.frac};
      exp_n    = EXP_W'(src.exp - 8'(EXP_OFFSET));
      keep_n   = src.frac[WFRAC_W-1 -: FRAC_W];
      guard_n  = src.frac[DROP_W-1];
      sticky_n = |src.frac[DROP_W-2:0];
   end

   // denormal path: align significant to the fixed denormal quantum
   always_comb begin
      den_sh   = 9'(DEN_BASE) - {1'b0, src.exp};
      sh_c     = (den_sh > 9'(SH_MAX)) ? 6'(SH_MAX) : den_sh[5:0];
      ext      = {mant, {(WFRAC_W+1){1'b0}}} >> sh_c;
      keep_d   = FRAC_W'(ext >> (WFRAC_W + 1));
      guard_d  = ext[WFRAC_W];
      sticky_d = |ext[WFRAC_W-1:0];
   end

   // shared rounding adder; a carry walks into the exponent field
   always_comb begin
      is_sat  = src.exp > 8'(TOP_BIASED);
      is_norm = src.exp > 8'(EXP_OFFSET);
      base    = is_norm ? {exp_n, keep_n} : {{EXP_W{1'b0}}, keep_d};
      guard   = is_norm ? guard_n  : guard_d;
      sticky  = is_norm ? sticky_n : sticky_d;
      rnd     = guard & (sticky | base[0]);
      sum     = {1'b0, base} + {{MAG_W{1'b0}}, rnd};
      mag     = (is_sat || sum[MAG_W]) ? {MAG_W{1'b1}} : sum[MAG_W-1:0];
      code    = {src.sign, mag};
   end
endmodule

// File: rtl/sfp_unpack.sv
module sfp_unpack
   import sfp_pkg::*;
#(
   parameter int unsigned EXP_W      = 4,
   parameter int unsigned FRAC_W     = 11,
   parameter int unsigned EXP_OFFSET = 120
) (
   input  logic [EXP_W+FRAC_W:0]  code,
   output word_fp_t               dst
);
   localparam int unsigned SW     = 1 + EXP_W + FRAC_W;
   localparam int unsigned DROP_W = WFRAC_W - FRAC_W;
   localparam int unsigned CW     = $clog2(FRAC_W + 1);

   logic               sgn;
   logic [EXP_W-1:0]   e_f;
   logic [FRAC_W-1:0]  f_f, f_norm;
   logic [CW-1:0]      lz;

   assign sgn = code[SW-1];
   assign e_f = code[SW-2 -: EXP_W];
   assign f_f = code[FRAC_W-1:0];

   sfp_lzc #(.W(FRAC_W)) u_lzc (
      .vec   (f_f),
      .count (lz)
   );

   always_comb begin
      f_norm   = (f_f << lz) << 1;
      dst.sign = sgn;
      if (e_f != '0) begin
         dst.exp  = 8'(e_f) + 8'(EXP_OFFSET);
         dst.frac = {f_f, {DROP_W{1'b0}}};
      end else if (f_f == '0) begin
         dst.exp  = '0;
         dst.frac = '0;
      end else begin
         dst.exp  = 8'(EXP_OFFSET) - 8'(lz);
         dst.frac = {f_norm, {DROP_W{1'b0}}};
      end
   end
endmodule

// File: rtl/sfp_convert.sv
module sfp_convert
   import sfp_pkg::*;
#(
   parameter int unsigned EXP_W      = 4,
   parameter int unsigned FRAC_W     = 11,
   parameter int unsigned EXP_OFFSET = 120
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         valid_in,
   input  logic         mode_in,
   input  logic [31:0]  data_in,
   output logic         valid_out,
   output logic [31:0]  data_out
);
   localparam int unsigned SW = 1 + EXP_W + FRAC_W;

   if (FRAC_W < 2 || FRAC_W > WFRAC_W - 2) begin : g_bad_frac
      $error("sfp_convert: FRAC_W out of range");
   end
   if (EXP_W < 1 || EXP_W > 7) begin : g_bad_exp
      $error("sfp_convert: EXP_W out of range");
   end
   if (EXP_OFFSET < FRAC_W || EXP_OFFSET + (2**EXP_W) - 1 > 254) begin : g_bad_off
      $error("sfp_convert: EXP_OFFSET leaves the single-precision range");
   end
   if (SW > WORD_W) begin : g_bad_sw
      $error("sfp_convert: short code wider than the word");
   end

   logic          s1_valid;
   dir_e          s1_dir;
   logic [31:0]   s1_data;
   logic [SW-1:0] pack_code;
   word_fp_t      unpack_word;

   // stage 1: capture operands
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_dir   <= DIR_PACK;
         s1_data  <= '0;
      end else begin
         s1_valid <= valid_in;
         s1_dir   <= dir_e'(mode_in);
         s1_data  <= data_in;
      end
   end

   sfp_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .EXP_OFFSET(EXP_OFFSET)) u_pack (
      .src  (word_fp_t'(s1_data)),
      .code (pack_code)
   );

   sfp_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .EXP_OFFSET(EXP_OFFSET)) u_unpack (
      .code (s1_data[SW-1:0]),
      .dst  (unpack_word)
   );

   // stage 2: register the selected result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_out <= 1'b0;
         data_out  <= '0;
      end else begin
         valid_out <= s1_valid;
         data_out  <= (s1_dir == DIR_UNPACK) ? unpack_word : 32'(pack_code);
      end
   end
endmodule

// File: rtl/sfp_convert_chk.sv
module sfp_convert_chk #(
   parameter int unsigned EXP_W      = 4,
   parameter int unsigned FRAC_W     = 11,
   parameter int unsigned EXP_OFFSET = 120
) (
   input logic         clk,
   input logic         rst_n,
   input logic         valid_in,
   input logic         mode_in,
   input logic [31:0]  data_in,
   input logic         valid_out,
   input logic [31:0]  data_out
);
   localparam int unsigned SW        = 1 + EXP_W + FRAC_W;
   localparam int unsigned MAG_W     = EXP_W + FRAC_W;
   localparam int unsigned SAT_ABOVE = EXP_OFFSET + (2**EXP_W) - 1;
   localparam int unsigned DROP_W    = 23 - FRAC_W;

   logic [1:0] warm;
   logic       settled;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             warm <= 2'd0;
      else if (warm != 2'd2)  warm <= warm + 2'd1;
   end
   assign settled = (warm == 2'd2);

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      settled |-> (valid_out == $past(valid_in, 2))); // R1

   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |=> !valid_out); // R2

   if (SW < 32) begin : g_high
      AST_PACK_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (settled && valid_out && !$past(mode_in, 2)) |-> (data_out[31:SW] == '0)); // R3
   end

   AST_PACK_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (settled && valid_out && !$past(mode_in, 2)) |-> (data_out[SW-1] == $past(data_in[31], 2))); // R3

   AST_PACK_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (settled && valid_out && !$past(mode_in, 2)
       && ($past(data_in[30:23], 2) > 8'(EXP_OFFSET))
       && ($past(data_in[30:23], 2) <= 8'(SAT_ABOVE))
       && ($past(data_in[DROP_W-1:0], 2) == '0))
      |-> (data_out[MAG_W-1:0] == {EXP_W'($past(data_in[30:23], 2) - 8'(EXP_OFFSET)),
                                   $past(data_in[22 -: FRAC_W], 2)})); // R3

   AST_PACK_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (settled && valid_out && !$past(mode_in, 2) && ($past(data_in[30:23], 2) > 8'(SAT_ABOVE)))
      |-> (data_out[MAG_W-1:0] == {MAG_W{1'b1}})); // R5

   AST_UNPACK_NORM_EXP: assert property (@(posedge clk) disable iff (!rst_n)
      (settled && valid_out && $past(mode_in, 2) && ($past(data_in[SW-2 -: EXP_W], 2) != '0))
      |-> (data_out[30:23] == 8'($past(data_in[SW-2 -: EXP_W], 2)) + 8'(EXP_OFFSET))); // R8

   AST_UNPACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (settled && valid_out && $past(mode_in, 2) && ($past(data_in[MAG_W-1:0], 2) == '0))
      |-> (data_out[30:0] == '0)); // R10
endmodule

bind sfp_convert sfp_convert_chk #(
   .EXP_W      (EXP_W),
   .FRAC_W     (FRAC_W),
   .EXP_OFFSET (EXP_OFFSET)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .valid_in  (valid_in),
   .mode_in   (mode_in),
   .data_in   (data_in),
   .valid_out (valid_out),
   .data_out  (data_out)
);

// File: tb/sim_sfp_convert.sv
module sim_sfp_convert;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        valid_in, mode_in;
   logic [31:0] data_in;
   logic        valid_out;
   logic [31:0] data_out;
   int          n_checks = 0;
   int          n_fail   = 0;
   logic [31:0] rng = 32'h1234_5679;

   always #5 clk = ~clk;

   sfp_convert u0 (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .mode_in(mode_in),
      .data_in(data_in), .valid_out(valid_out), .data_out(data_out)
   );

   // ---------------- reference arithmetic ----------------
   function automatic real pow2(int k);
      real r = 1.0;
      if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
      else        for (int i = 0; i < -k; i++) r = r / 2.0;
      return r;
   endfunction

   function automatic real word_mag(logic [31:0] w);
      int  e  = int'(w[30:23]);
      real fr = real'(w[22:0]);
      if (e == 0) return fr * pow2(-149);
      return (1.0 + fr / 8388608.0) * pow2(e - 127);
   endfunction

   function automatic logic [15:0] ref_pack(logic [31:0] w);
      int  e = int'(w[30:23]);
      real a = word_mag(w);
      real q, n, fl;
      int  c;
      if (e >= 136) c = 32767;
      else begin
         q  = (e >= 121) ? pow2(e - 138) : pow2(-17);
         n  = a / q;
         fl = $floor(n);
         if ((n - fl) > 0.5 || ((n - fl) == 0.5 && (int'(fl) % 2 == 1))) fl = fl + 1.0;
         c  = (e >= 121) ? ((e - 120) * 2048 + int'(fl) - 2048) : int'(fl);
         if (c > 32767) c = 32767;
      end
      return {w[31], c[14:0]};
   endfunction

   function automatic real ref_short_mag(logic [15:0] s);
      int e = int'(s[14:11]);
      int f = int'(s[10:0]);
      if (e != 0) return (1.0 + real'(f) / 2048.0) * pow2(e - 7);
      return real'(f) * pow2(-17);
   endfunction

   // ---------------- check helpers ----------------
   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_unpack(logic [15:0] s, logic [31:0] act);
      string req;
      bit    ok;
      req = (s[14:11] != 0) ? "R8" : ((s[10:0] != 0) ? "R9" : "R10");
      ok  = (act[31] == s[15]) && (act[30:23] != 8'hFF) && (word_mag(act) == ref_short_mag(s));
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s unpack %h: got %h expected sign %b magnitude %e",
                  req, s, act, s[15], ref_short_mag(s));
      end
   endtask

   task automatic do_one(logic mode, logic [31:0] din, output logic [31:0] dout, output logic vout);
      @(negedge clk);
      valid_in = 1'b1; mode_in = mode; data_in = din;
      @(negedge clk);
      valid_in = 1'b0; data_in = 32'h0;
      @(negedge clk);
      dout = data_out; vout = valid_out;
   endtask

   task automatic pack_case(string req, logic [31:0] din, logic [15:0] exp);
      logic [31:0] o; logic v;
      do_one(1'b0, din, o, v);
      check(req, $sformatf("pack %h", din), o, {16'h0, exp});
   endtask

   task automatic unpack_case(string req, logic [31:0] din, logic [31:0] exp);
      logic [31:0] o; logic v;
      do_one(1'b1, din, o, v);
      check(req, $sformatf("unpack %h", din), o, exp);
   endtask

   function automatic logic [31:0] next_rng(logic [31:0] x);
      logic [31:0] y = x;
      y = y ^ (y << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
      return y;
   endfunction

   // ---------------- scenarios ----------------
   task automatic t_reset();
      @(negedge clk);
      valid_in = 1'b1; mode_in = 1'b0; data_in = 32'h3F80_0000;
      repeat (2) @(negedge clk);
      check("R2", "valid_out in reset", {31'h0, valid_out}, 32'h0);
      check("R2", "data_out in reset", data_out, 32'h0);
      valid_in = 1'b0; data_in = 32'h0;
      @(negedge clk); rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R2", "no result after reset release", {31'h0, valid_out}, 32'h0);
   endtask

   task automatic t_latency();
      @(negedge clk);
      valid_in = 1'b1; mode_in = 1'b0; data_in = 32'h3F80_0000;
      @(negedge clk);
      valid_in = 1'b0;
      check("R1", "valid_out after one edge", {31'h0, valid_out}, 32'h0);
      @(negedge clk);
      check("R1", "valid_out after two edges", {31'h0, valid_out}, 32'h1);
      check("R1", "data after two edges", data_out, 32'h0000_3800);
      @(negedge clk);
      check("R1", "valid_out after three edges", {31'h0, valid_out}, 32'h0);
      // back to back with a direction change
      valid_in = 1'b1; mode_in = 1'b0; data_in = 32'hBFC0_0000;
      @(negedge clk);
      valid_in = 1'b1; mode_in = 1'b1; data_in = 32'h0000_3800;
      @(negedge clk);
      valid_in = 1'b0; data_in = 32'h0;
      check("R1", "first of pair", {valid_out, data_out[30:0]}, {1'b1, 31'h0000_BC00});
      @(negedge clk);
      check("R1", "second of pair valid", {31'h0, valid_out}, 32'h1);
      check("R1", "second of pair data", data_out, 32'h3F80_0000);
   endtask

   task automatic t_pack_directed();
      pack_case("R3", 32'h3F80_0000, 16'h3800);
      pack_case("R3", 32'hBFC0_0000, 16'hBC00);
      pack_case("R3", 32'h3C80_0000, 16'h0800);
      pack_case("R3", 32'hC3FF_F000, 16'hFFFF);
      pack_case("R4", 32'h3F80_0800, 16'h3800);
      pack_case("R4", 32'h3F80_1800, 16'h3802);
      pack_case("R4", 32'h3F80_0801, 16'h3801);
      pack_case("R4", 32'h3FFF_F800, 16'h4000);
      pack_case("R4", 32'h43FF_E800, 16'h7FFE);
      pack_case("R5", 32'h4780_0000, 16'h7FFF);
      pack_case("R5", 32'hFF80_0000, 16'hFFFF);
      pack_case("R5", 32'h43FF_F800, 16'h7FFF);
      pack_case("R5", 32'h7FC0_0001, 16'h7FFF);
      pack_case("R6", 32'h3C00_0000, 16'h0400);
      pack_case("R6", 32'h3700_0000, 16'h0001);
      pack_case("R6", 32'h3740_0000, 16'h0002);
      pack_case("R6", 32'h3BFF_FFFF, 16'h0400);
      pack_case("R6", 32'h3C7F_FFFF, 16'h0800);
      pack_case("R6", 32'h3680_0001, 16'h0001);
      pack_case("R6", 32'h36C0_0000, 16'h0001);
      pack_case("R7", 32'h3680_0000, 16'h0000);
      pack_case("R7", 32'h0000_0000, 16'h0000);
      pack_case("R7", 32'h8000_0000, 16'h8000);
      pack_case("R7", 32'h0000_0001, 16'h0000);
      pack_case("R7", 32'h8DAD_0000, 16'h8000);
   endtask

   task automatic t_pack_sweep();
      logic [31:0] w, o; logic v; int e; string req;
      for (int i = 0; i < 3000; i++) begin
         rng = next_rng(rng);
         e   = 100 + int'(rng[15:8]) % 42;
         w   = {rng[31], 8'(e), 23'h0};
         rng = next_rng(rng);
         w[22:0] = rng[22:0];
         if (i % 8 == 7) w = rng;
         e   = int'(w[30:23]);
         req = (e >= 136) ? "R5" : ((e >= 121) ? "R4" : "R6");
         do_one(1'b0, w, o, v);
         check(req, $sformatf("pack sweep %h", w), o, {16'h0, ref_pack(w)});
      end
   endtask

   task automatic t_unpack_directed();
      unpack_case("R8",  32'h0000_3800, 32'h3F80_0000);
      unpack_case("R8",  32'h0000_FFFF, 32'hC3FF_F000);
      unpack_case("R8",  32'hABCD_3800, 32'h3F80_0000);
      unpack_case("R9",  32'h0000_0001, 32'h3700_0000);
      unpack_case("R9",  32'h0000_0400, 32'h3C00_0000);
      unpack_case("R9",  32'h0000_07FF, 32'h3C7F_E000);
      unpack_case("R10", 32'h0000_8000, 32'h8000_0000);
      unpack_case("R10", 32'h0000_0000, 32'h0000_0000);
   endtask

   // unpack every code, feed each result straight back through pack
   task automatic t_roundtrip();
      int          kind [4];
      logic [15:0] tag [4];
      int          next = 0;
      int          missing = 0;
      int          ps, cur;
      for (int i = 0; i < 4; i++) kind[i] = 0;
      for (int n = 0; n < 131074; n++) begin
         @(negedge clk);
         ps  = (n + 2) % 4;
         cur = kind[ps];
         kind[ps] = 0;
         valid_in = 1'b0; data_in = 32'h0;
         if (cur != 0 && !valid_out) missing++;
         if (cur == 1) begin
            check_unpack(tag[ps], data_out);
            valid_in = 1'b1; mode_in = 1'b0; data_in = data_out;
            kind[n % 4] = 2; tag[n % 4] = tag[ps];
         end else if (cur == 2) begin
            check("R11", $sformatf("round trip %h", tag[ps]), data_out, {16'h0, tag[ps]});
         end
         if (cur != 1 && next < 65536) begin
            valid_in = 1'b1; mode_in = 1'b1; data_in = {16'h0, 16'(next)};
            kind[n % 4] = 1; tag[n % 4] = 16'(next);
            next++;
         end
      end
      @(negedge clk); valid_in = 1'b0;
      check("R1", "results missing in streaming", 32'(missing), 32'h0);
   endtask

   initial begin
      for (int c = 0; c < 195000; c++) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; valid_in = 1'b0; mode_in = 1'b0; data_in = 32'h0;
      t_reset();
      t_latency();
      t_pack_directed();
      t_unpack_directed();
      t_pack_sweep();
      t_roundtrip();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule